// File: doc/BRIEF.md
# Multi-Format Serial Stereo Audio Receiver

This block takes stereo audio from a three-wire serial link (a bit clock, a framing clock that tells the two channels apart, and a data line) and delivers parallel left/right sample pairs in the local system clock domain. All three pins are sampled by the system clock. The bit clock is found by edge detection after a synchronizer, so the bit clock need not be related to the system clock or to the framing clock. The number of bit-clock periods in a channel slot is never assumed.

A two-bit format input selects one of four framings, and a width input selects 16-bit or 18-bit words. Words arrive most significant bit first in two's complement. Every sample leaves as an 18-bit two's-complement value whose MSB is always at the top. Format and width are meant to stay fixed while a stream runs and are changed while reset is held.

The output is a valid/ready stream. A pair is offered with `out_valid` and is taken on a cycle where `out_valid` and `out_ready` are both high. While the pair waits for `out_ready`, it is held unchanged. A pair that completes during that wait is discarded. A pair that completes in the same cycle as a handshake is loaded in place of the one leaving.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_sel` encodes the framing: 0 left-justified, 1 I2S, 2 right-justified, 3 DSP pulse. `long_word` high selects 18-bit words and low selects 16-bit words.
- R2: Serial words are MSB first in two's complement. Outputs are 18 bits wide. A 16-bit word occupies bits 17:2 and bits 1:0 are zero.
- R3: Left-justified: a rising bit-clock edge at which the framing level differs from the previous edge carries the MSB. The framing level low marks the left channel. The N bits from that edge on form the word, and any later bits of the slot are ignored.
- R4: I2S: the bit at the edge where the framing level changes is ignored. The MSB is on the next rising edge, and the channel polarity is the same as in R3.
- R5: Right-justified: at each framing change, the last N bits sampled before that edge form the word of the channel that just ended. Earlier bits of the slot are ignored.
- R6: DSP: an edge that sees the framing level high after it was low marks a frame start. The next N edges carry the left word and the N edges after them carry the right word. Further bits are ignored until the next start.
- R7: Any number of extra bit-clock periods per slot is accepted without changing the captured words.
- R8: A pair is produced only when a right word completes after a left word of the same frame. A right word with no left word before it is dropped.
- R9: While `out_valid` is high and `out_ready` is low, the outputs hold. A pair completing in that time is discarded.
- R10: After reset `out_valid` is low and no partial frame is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bitclk_pin | input | 1 | Serial bit clock; data is taken on its rising edge |
| frame_pin | input | 1 | Framing clock separating left and right |
| data_pin | input | 1 | Serial audio data |
| fmt_sel | input | 2 | Framing format select (R1) |
| long_word | input | 1 | 1: 18-bit words, 0: 16-bit words |
| out_valid | output | 1 | Sample pair offered |
| out_ready | input | 1 | Consumer accepts the pair |
| out_left | output | 18 | Left sample, MSB aligned |
| out_right | output | 18 | Right sample, MSB aligned |

## Verification
A wrong bit counter or a wrong start condition in the framer shifts every captured word by one or more bit positions. That shows as a wrong `out_left`/`out_right` value in the first pair after the fault. A lost left/right pairing flag shows as a missing pair or an extra pair, which appears within one frame as a count mismatch between expected and received pairs. A broken hold path in the output stage shows as a change on the data outputs in the cycle after `out_valid` is left unaccepted.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  typedef enum logic [1:0] {
    FMT_LEFT  = 2'd0,
    FMT_I2S   = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_DSP   = 2'd3
  } fmt_e;
endpackage

// File: rtl/sar_pin_sync.sv
`timescale 1ns/1ps
module sar_pin_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], pin_i};
  end

  assign pin_o = stage_q[STAGES-1];
endmodule

// File: rtl/sar_framer.sv
`timescale 1ns/1ps
module sar_framer
  import sar_pkg::*;
#(
  parameter int OUT_W   = 18,
  parameter int SHORT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_rise,
  input  logic             frm,
  input  logic             dat,
  input  fmt_e             fmt,
  input  logic             long_word,
  output logic             word_stb,
  output logic             word_right,
  output logic [OUT_W-1:0] word_data
);
  localparam int CW   = $clog2(OUT_W + 1);
  localparam int PADW = OUT_W - SHORT_W;

  logic             seen_q, frm_prev_q, active_q, pend_q, right_q;
  logic [OUT_W-1:0] shreg_q;
  logic [CW-1:0]    cnt_q;
  logic             stb_q, stb_right_q;
  logic [OUT_W-1:0] data_q;

  logic [CW-1:0]    nbits, last_idx;
  logic [OUT_W-1:0] shifted;
  logic             changed;

  assign nbits    = long_word ? CW'(OUT_W) : CW'(SHORT_W);
  assign last_idx = nbits - CW'(1);
  assign shifted  = {shreg_q[OUT_W-2:0], dat};
  assign changed  = seen_q && (frm != frm_prev_q);

  function automatic logic [OUT_W-1:0] align(input logic [OUT_W-1:0] src, input logic lw);
    return lw ? src : {src[SHORT_W-1:0], {PADW{1'b0}}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      frm_prev_q  <= 1'b0;
      active_q    <= 1'b0;
      pend_q      <= 1'b0;
      right_q     <= 1'b0;
      shreg_q     <= '0;
      cnt_q       <= '0;
      stb_q       <= 1'b0;
      stb_right_q <= 1'b0;
      data_q      <= '0;
    end else begin
      stb_q <= 1'b0;
      if (bit_rise) begin
        seen_q     <= 1'b1;
        frm_prev_q <= frm;
        shreg_q    <= shifted;
        unique case (fmt)
          FMT_LEFT, FMT_I2S: begin
            if (changed) begin
              right_q  <= frm;
              pend_q   <= (fmt == FMT_I2S);
              active_q <= (fmt == FMT_LEFT);
              cnt_q    <= CW'(1);
            end else if (pend_q) begin
              pend_q   <= 1'b0;
              active_q <= 1'b1;
              cnt_q    <= CW'(1);
            end else if (active_q) begin
              if (cnt_q == last_idx) begin
                stb_q       <= 1'b1;
                stb_right_q <= right_q;
                data_q      <= align(shifted, long_word);
                active_q    <= 1'b0;
              end else begin
                cnt_q <= cnt_q + CW'(1);
              end
            end
          end
          FMT_RIGHT: begin
            if (changed) begin
              stb_q       <= 1'b1;
              stb_right_q <= frm_prev_q;
              data_q      <= align(shreg_q, long_word);
            end
          end
          FMT_DSP: begin
            if (changed && frm) begin
              pend_q   <= 1'b1;
              active_q <= 1'b0;
              right_q  <= 1'b0;
            end else if (pend_q) begin
              pend_q   <= 1'b0;
              active_q <= 1'b1;
              cnt_q    <= CW'(1);
            end else if (active_q) begin
              if (cnt_q == last_idx) begin
                stb_q       <= 1'b1;
                stb_right_q <= right_q;
                data_q      <= align(shifted, long_word);
                cnt_q       <= '0;
                if (right_q) active_q <= 1'b0;
                else         right_q  <= 1'b1;
              end else begin
                cnt_q <= cnt_q + CW'(1);
              end
            end
          end
        endcase
      end
    end
  end

  assign word_stb   = stb_q;
  assign word_right = stb_right_q;
  assign word_data  = data_q;

  // A word is only completed by a bit-clock edge (R7: no fixed slot length assumed)
  assert_word_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(bit_rise));

  // Bit counter never runs past the selected word length (R6, R3)
  assert_count_in_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < nbits));
endmodule

// File: rtl/sar_pair_out.sv
`timescale 1ns/1ps
module sar_pair_out #(
  parameter int OUT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_stb,
  input  logic             word_right,
  input  logic [OUT_W-1:0] word_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_left,
  output logic [OUT_W-1:0] out_right
);
  logic             have_left_q, valid_q;
  logic [OUT_W-1:0] left_hold_q, left_q, right_q;
  logic             pair_stb;

  assign pair_stb = word_stb && word_right && have_left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_left_q <= 1'b0;
      left_hold_q <= '0;
      valid_q     <= 1'b0;
      left_q      <= '0;
      right_q     <= '0;
    end else begin
      if (word_stb) begin
        have_left_q <= !word_right;
        if (!word_right) left_hold_q <= word_data;
      end
      if (pair_stb && (!valid_q || out_ready)) begin
        valid_q <= 1'b1;
        left_q  <= left_hold_q;
        right_q <= word_data;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_left  = left_q;
  assign out_right = right_q;

  // Unaccepted pair stays put (R9)
  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  // A new pair only follows a completed right word (R8)
  assert_pair_after_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(word_stb && word_right));
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OUT_W       = 18,
  parameter int SHORT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bitclk_pin,
  input  logic             frame_pin,
  input  logic             data_pin,
  input  logic [1:0]       fmt_sel,
  input  logic             long_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_left,
  output logic [OUT_W-1:0] out_right
);
  localparam int PADW = OUT_W - SHORT_W;

  logic [2:0]       pins_s;
  logic             bit_prev_q, bit_rise;
  logic             word_stb, word_right;
  logic [OUT_W-1:0] word_data;

  sar_pin_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({bitclk_pin, frame_pin, data_pin}),
    .pin_o (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_prev_q <= 1'b0;
    else        bit_prev_q <= pins_s[2];
  end

  assign bit_rise = pins_s[2] && !bit_prev_q;

  sar_framer #(.OUT_W(OUT_W), .SHORT_W(SHORT_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_rise   (bit_rise),
    .frm        (pins_s[1]),
    .dat        (pins_s[0]),
    .fmt        (fmt_e'(fmt_sel)),
    .long_word  (long_word),
    .word_stb   (word_stb),
    .word_right (word_right),
    .word_data  (word_data)
  );

  sar_pair_out #(.OUT_W(OUT_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_stb   (word_stb),
    .word_right (word_right),
    .word_data  (word_data),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_left   (out_left),
    .out_right  (out_right)
  );

  // Short words leave the low bits clear (R2)
  assert_short_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !long_word) |->
      (out_left[PADW-1:0] == '0 && out_right[PADW-1:0] == '0));
endmodule

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bitclk_pin = 1'b0;
  logic        frame_pin = 1'b1;
  logic        data_pin = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        long_word = 1'b1;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [17:0] out_left, out_right;

  int checks = 0;
  int failures = 0;
  int got = 0;
  int seed_v;
  string cur_tag = "R3";
  logic [35:0] expq[$];

  serial_audio_rx uut (
    .clk(clk), .rst_n(rst_n), .bitclk_pin(bitclk_pin), .frame_pin(frame_pin),
    .data_pin(data_pin), .fmt_sel(fmt_sel), .long_word(long_word),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2: 16-bit words sit in bits 17:2 with zero fill
  function automatic logic [17:0] aligned(input logic [17:0] w, input logic lw);
    return lw ? w : {w[15:0], 2'b00};
  endfunction

  // Monitor: every handshake must match the next expected pair
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      got++;
      if (expq.size() == 0) begin
        check(1'b0, {cur_tag, "/R8 unexpected pair"}, {out_left, out_right}, 36'd0);
      end else begin
        logic [35:0] e;
        e = expq.pop_front();
        check({out_left, out_right} == e, {cur_tag, "/R2/R7 pair"}, {out_left, out_right}, e);
      end
    end
  end

  task automatic slot(input logic f, input logic d);
    bitclk_pin = 1'b0; frame_pin = f; data_pin = d;
    repeat (4) @(negedge clk);
    bitclk_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic word_bits(input logic f, input logic [17:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) slot(f, w[i]);
  endtask

  task automatic pad(input logic f, input int k);
    for (int i = 0; i < k; i++) slot(f, 1'($urandom()));
  endtask

  task automatic send_frame(input int mode, input logic lw, input logic [17:0] l,
                            input logic [17:0] r, input logic push);
    int n;
    int p1, p2;
    n  = lw ? 18 : 16;
    p1 = int'($urandom() % 6);
    p2 = int'($urandom() % 6);
    if (push) expq.push_back({aligned(l, lw), aligned(r, lw)});
    case (mode)
      0: begin word_bits(0, l, n); pad(0, p1); word_bits(1, r, n); pad(1, p2); end
      1: begin slot(0, 1'($urandom())); word_bits(0, l, n); pad(0, p1);
               slot(1, 1'($urandom())); word_bits(1, r, n); pad(1, p2); end
      2: begin pad(0, p1); word_bits(0, l, n); pad(1, p2); word_bits(1, r, n); end
      default: begin slot(1, 1'($urandom())); word_bits(0, l, n); word_bits(0, r, n); pad(0, p1); end
    endcase
  endtask

  task automatic start_group(input int mode, input logic lw, input logic idle);
    rst_n = 1'b0;
    fmt_sel = 2'(mode);
    long_word = lw;
    bitclk_pin = 1'b0;
    frame_pin = idle;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) slot(idle, 1'b0);
  endtask

  task automatic run_group(input int mode, input logic lw, input int nframes);
    logic [17:0] mx, mn;
    mx = lw ? 18'h1FFFF : 18'h07FFF;
    mn = lw ? 18'h20000 : 18'h08000;
    // R1 encodes the mode; tags R3 (0), R4 (1), R5 (2), R6 (3)
    case (mode)
      0: cur_tag = "R1/R3";
      1: cur_tag = "R1/R4";
      2: cur_tag = "R1/R5";
      default: cur_tag = "R1/R6";
    endcase
    start_group(mode, lw, (mode == 3) ? 1'b0 : 1'b1);
    send_frame(mode, lw, mx, mn, 1'b1);
    send_frame(mode, lw, mn, mx, 1'b1);
    for (int i = 0; i < nframes; i++)
      send_frame(mode, lw, 18'($urandom()), 18'($urandom()), 1'b1);
    if (mode == 2) slot(0, 1'b0);   // R5: closing change delivers the last right word
    repeat (20) @(negedge clk);
    check(expq.size() == 0, {cur_tag, "/R7 all pairs delivered"}, 36'(expq.size()), 36'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [17:0] a_l, a_r;
    int got0;
    seed_v = int'($urandom(32'd20240611));

    // R10: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 valid in reset", 36'(out_valid), 36'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 valid after reset", 36'(out_valid), 36'd0);

    for (int m = 0; m < 4; m++) begin
      run_group(m, 1'b1, 4);
      run_group(m, 1'b0, 4);
    end

    // R8: right word with no left word before it is dropped
    cur_tag = "R8";
    start_group(0, 1'b1, 1'b0);
    word_bits(1, 18'h2AAAA, 18);
    pad(1, 2);
    send_frame(0, 1'b1, 18'h0F0F0, 18'h30303, 1'b1);
    repeat (20) @(negedge clk);
    check(expq.size() == 0 && got > 0, "R8 orphan right dropped", 36'(expq.size()), 36'd0);

    // R9: back-pressure holds the first pair and drops the second
    cur_tag = "R9";
    start_group(0, 1'b1, 1'b1);
    out_ready = 1'b0;
    a_l = 18'h12345; a_r = 18'h3CDEF;
    send_frame(0, 1'b1, a_l, a_r, 1'b1);
    repeat (20) @(negedge clk);
    check(out_valid == 1'b1, "R9 valid while stalled", 36'(out_valid), 36'd1);
    check({out_left, out_right} == {a_l, a_r}, "R9 first pair offered", {out_left, out_right}, {a_l, a_r});
    send_frame(0, 1'b1, 18'h05555, 18'h0AAAA, 1'b0);
    repeat (20) @(negedge clk);
    check({out_left, out_right} == {a_l, a_r}, "R9 held during stall", {out_left, out_right}, {a_l, a_r});
    got0 = got;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(got == got0 + 1, "R9 one handshake", 36'(got), 36'(got0 + 1));
    check(out_valid == 1'b0, "R9 stalled pair discarded", 36'(out_valid), 36'd0);
    send_frame(0, 1'b1, 18'h00001, 18'h3FFFF, 1'b1);
    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R9 stream resumes", 36'(expq.size()), 36'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule